// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects 32 parent interrupt sources and presents one request line to the processor. Four of the parent positions are not driven by wires. Each of them is the OR of a small group of sub-sources: three groups of three events for three serial ports (receive, transmit, error), and one group of two events for an analogue converter (touch, conversion finished). Every sub-source has its own pending and mask bit. Every parent has a source-pending bit and a mask bit. A separate interrupt-pending register holds the single source that is currently being serviced.

Software works through a small register port. It unmasks sources by writing the mask registers. It reads the pending registers to find the cause. It acknowledges by writing ones to the pending registers, and each of those writes clears only the bits written as one. Priority is fixed: the lowest-numbered pending source that is not masked wins, and it is latched only when no other source is held. Rotation, vectoring and a fast-interrupt path are not provided.

Top module: `casc_intc`

## Requirements
- R1: After reset the main mask reads 0xFFFFFFFF and the sub-mask reads 0x7FF. The source-pending, interrupt-pending and sub-pending registers read 0, and irq_o is 0.
- R2: For a parent that is not cascaded, a rising edge on src_in[i] sets source-pending bit i on the clock edge that first samples the input high. The cascaded positions are 15, 23, 28 and 31, and their src_in bits have no effect.
- R3: A rising edge on sub_in[j] sets sub-pending bit j whether or not it is masked. Bits 0, 1 and 2 are the receive, transmit and error events of serial port 0 (parent 28). Bits 3 to 5 belong to port 1 (parent 23), bits 6 to 8 to port 2 (parent 15), and bits 9 (touch) and 10 (conversion done) to the converter (parent 31).
- R4: A cascaded parent's source-pending bit is set on every edge while any sub-pending bit of its group is 1 with its sub-mask bit 0. The bit is therefore set again after a clear while that sub-source is still pending. Masked sub-sources never set it.
- R5: A write to the source-pending, interrupt-pending or sub-pending register clears exactly the bits written as 1 and leaves all others. If a set event arrives in the same cycle, the set takes effect.
- R6: The interrupt-pending register holds at most one bit. When it is empty (after any clear in the same cycle), it loads the lowest-numbered bit of source-pending that has its main mask bit 0. While it holds a bit, that bit is kept even if a lower-numbered source becomes pending.
- R7: irq_o is 1 exactly when the interrupt-pending bit it holds has its main mask bit 0. Setting that mask bit drops irq_o on the edge of the write, and clearing it raises irq_o again.
- R8: Register addresses are 0 source-pending, 1 main mask, 2 interrupt-pending, 3 sub-pending and 4 sub-mask. Mask writes replace the whole register. rdata shows the addressed register one edge after addr is presented. Other addresses read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Parent source inputs, edge detected |
| sub_in | input | 11 | Sub-source event inputs, edge detected |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data: mask value or bits to clear |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered request to the processor |

## Verification
On every cycle the assertions check the following. The interrupt-pending register is never more than one-hot. A held bit stays until it is written away. irq_o agrees with the held bit and its mask. A rising parent edge always lands in source-pending. A live unmasked sub-source always drives its parent. A sub-pending clear always takes effect unless an edge arrives in the same cycle. Some behaviour needs ordered stimulus, and only the bench scenarios show it: the priority order across several simultaneous sources, handover to the next source after an acknowledge, the re-set of a cascaded parent while its sub-source is still pending, the register map, and the reset values.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;
  localparam int NUM_SRC       = 32;
  localparam int NPORT         = 3;
  localparam int SUBS_PER_PORT = 3;
  localparam int CONV_SUBS     = 2;
  localparam int NUM_SUB       = NPORT * SUBS_PER_PORT + CONV_SUBS;
  localparam int NGRP          = NPORT + 1;
  localparam int ADDR_W        = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SRCPND  = 3'd0,
    A_MASK    = 3'd1,
    A_INTPND  = 3'd2,
    A_SUBPND  = 3'd3,
    A_SUBMASK = 3'd4
  } reg_addr_e;

  // parent position fed by each sub-source group
  function automatic int grp_parent(input int g);
    case (g)
      0:       return 28;
      1:       return 23;
      2:       return 15;
      default: return 31;
    endcase
  endfunction

  // sub-source bits belonging to group g
  function automatic logic [NUM_SUB-1:0] grp_bits(input int g);
    if (g < NPORT)
      return NUM_SUB'(((1 << SUBS_PER_PORT) - 1) << (g * SUBS_PER_PORT));
    else
      return NUM_SUB'(((1 << CONV_SUBS) - 1) << (NPORT * SUBS_PER_PORT));
  endfunction

  function automatic logic [NUM_SRC-1:0] casc_vec();
    logic [NUM_SRC-1:0] v;
    v = '0;
    for (int g = 0; g < NGRP; g++) v[grp_parent(g)] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/casc_intc_edge.sv
module casc_intc_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/casc_intc_pick.sv
module casc_intc_pick #(
  parameter int W = 32
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  // isolate the lowest set bit
  assign grant = req & (~req + W'(1));
endmodule

// File: rtl/casc_intc_sub.sv
module casc_intc_sub
  import casc_intc_pkg::*;
#(
  parameter int NSUB = NUM_SUB,
  parameter int NG   = NGRP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSUB-1:0] sub_in,
  input  logic            clr_en,
  input  logic            msk_we,
  input  logic [NSUB-1:0] wbits,
  output logic [NSUB-1:0] sub_pnd,
  output logic [NSUB-1:0] sub_msk,
  output logic [NG-1:0]   grp_hit
);
  logic [NSUB-1:0] sub_rise;
  logic [NSUB-1:0] clr_bits;

  casc_intc_edge #(.W(NSUB)) u_edge (
    .clk (clk),
    .rst (rst),
    .din (sub_in),
    .rise(sub_rise)
  );

  assign clr_bits = clr_en ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_pnd <= '0;
      sub_msk <= '1;
    end else begin
      sub_pnd <= (sub_pnd & ~clr_bits) | sub_rise;
      if (msk_we) sub_msk <= wbits;
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_hit[g] = |(sub_pnd & ~sub_msk & grp_bits(g));
  end

  // R5: written ones clear unless an edge arrives together
  a_r5_sub_w1c: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((sub_pnd & $past(clr_bits & ~sub_rise)) == '0));

  // R3: an edge always lands in sub-pending
  a_r3_sub_rise: assert property (@(posedge clk) disable iff (rst)
    (sub_rise != '0) |=> ((sub_pnd & $past(sub_rise)) == $past(sub_rise)));
endmodule

// File: rtl/casc_intc.sv
module casc_intc
  import casc_intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SUB-1:0] sub_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irq_o
);
  localparam logic [NUM_SRC-1:0] CASC = casc_vec();

  logic [NUM_SRC-1:0] src_pnd, src_mask, int_pnd;
  logic [NUM_SRC-1:0] src_rise, set_vec, pick;
  logic [NUM_SRC-1:0] src_pnd_n, mask_n, int_kept, int_n;
  logic [NUM_SUB-1:0] sub_pnd, sub_msk;
  logic [NGRP-1:0]    grp_hit;
  logic               wr_src, wr_msk, wr_int, wr_sub, wr_smsk, irq_n;

  assign wr_src  = wr_en && (addr == A_SRCPND);
  assign wr_msk  = wr_en && (addr == A_MASK);
  assign wr_int  = wr_en && (addr == A_INTPND);
  assign wr_sub  = wr_en && (addr == A_SUBPND);
  assign wr_smsk = wr_en && (addr == A_SUBMASK);

  casc_intc_edge #(.W(NUM_SRC)) u_src_edge (
    .clk (clk),
    .rst (rst),
    .din (src_in),
    .rise(src_rise)
  );

  casc_intc_sub #(.NSUB(NUM_SUB), .NG(NGRP)) u_sub (
    .clk    (clk),
    .rst    (rst),
    .sub_in (sub_in),
    .clr_en (wr_sub),
    .msk_we (wr_smsk),
    .wbits  (wdata[NUM_SUB-1:0]),
    .sub_pnd(sub_pnd),
    .sub_msk(sub_msk),
    .grp_hit(grp_hit)
  );

  casc_intc_pick #(.W(NUM_SRC)) u_pick (
    .req  (src_pnd & ~src_mask),
    .grant(pick)
  );

  always_comb begin
    set_vec = src_rise & ~CASC;
    for (int g = 0; g < NGRP; g++)
      set_vec[grp_parent(g)] = set_vec[grp_parent(g)] | grp_hit[g];
    src_pnd_n = (src_pnd & ~(wr_src ? wdata : '0)) | set_vec;
    mask_n    = wr_msk ? wdata : src_mask;
    int_kept  = int_pnd & ~(wr_int ? wdata : '0);
    int_n     = (int_kept != '0) ? int_kept : pick;
    irq_n     = |(int_n & ~mask_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_pnd  <= '0;
      src_mask <= '1;
      int_pnd  <= '0;
      irq_o    <= 1'b0;
      rdata    <= '0;
    end else begin
      src_pnd  <= src_pnd_n;
      src_mask <= mask_n;
      int_pnd  <= int_n;
      irq_o    <= irq_n;
      case (addr)
        A_SRCPND:  rdata <= src_pnd;
        A_MASK:    rdata <= src_mask;
        A_INTPND:  rdata <= int_pnd;
        A_SUBPND:  rdata <= NUM_SRC'(sub_pnd);
        A_SUBMASK: rdata <= NUM_SRC'(sub_msk);
        default:   rdata <= '0;
      endcase
    end
  end

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (src_mask == '1 && int_pnd == '0 && src_pnd == '0 && !irq_o));

  // R6: never more than one held source
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(int_pnd));

  // R6: a held source stays until written away
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (int_pnd != '0 && !wr_int) |=> (int_pnd == $past(int_pnd)));

  // R7: request agrees with held bit and its mask
  a_r7_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(int_pnd & ~src_mask));

  // R2: a direct edge always reaches source-pending
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    ((src_rise & ~CASC) != '0) |=>
      ((src_pnd & $past(src_rise & ~CASC)) == $past(src_rise & ~CASC)));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    localparam int P = grp_parent(g);
    // R4: a live unmasked sub-source drives its parent
    a_r4_parent_set: assert property (@(posedge clk) disable iff (rst)
      grp_hit[g] |=> src_pnd[P]);
  end
endmodule

// File: tb/casc_intc_tb_top.sv
module casc_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic [10:0] sub_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] CASCB = (32'h1 << 15) | (32'h1 << 23) | (32'h1 << 28) | (32'h1 << 31);

  always #5 clk = ~clk;

  casc_intc dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .sub_in(sub_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); wr_en = 1'b0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse_src(input logic [31:0] v);
    @(negedge clk); src_in = v;
    @(negedge clk); src_in = '0;
  endtask

  task automatic pulse_sub(input logic [10:0] v);
    @(negedge clk); sub_in = v;
    @(negedge clk); sub_in = '0;
  endtask

  function automatic int parent_of(input int j);
    if (j < 3) return 28;
    if (j < 6) return 23;
    if (j < 9) return 15;
    return 31;
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] pb;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(3'd1, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R1 submask", d, 32'h7FF);
    rd(3'd0, d); chk("R1 srcpnd", d, 32'h0);
    rd(3'd2, d); chk("R1 intpnd", d, 32'h0);
    rd(3'd3, d); chk("R1 subpnd", d, 32'h0);

    // R2/R6/R7/R5 sweep over direct parents
    for (int i = 0; i < 32; i++) begin
      if (CASCB[i]) continue;
      pb = 32'h1 << i;
      wr(3'd1, ~pb);
      pulse_src(pb);
      @(negedge clk);
      chk("R7 irq raised", {31'b0, irq_o}, 32'h1);
      rd(3'd2, d); chk("R6 intpnd single", d, pb);
      rd(3'd0, d); chk("R2 srcpnd edge", d, pb);
      wr(3'd0, pb);
      wr(3'd2, pb);
      chk("R5 irq after ack", {31'b0, irq_o}, 32'h0);
      rd(3'd2, d); chk("R5 intpnd cleared", d, 32'h0);
    end

    // R2 cascaded positions ignore src_in
    wr(3'd1, ~CASCB);
    pulse_src(CASCB);
    @(negedge clk); @(negedge clk);
    rd(3'd0, d); chk("R2 cascaded src_in ignored", d, 32'h0);
    chk("R2 no irq from cascaded src_in", {31'b0, irq_o}, 32'h0);

    // R3/R4 sweep over sub-sources
    for (int j = 0; j < 11; j++) begin
      pb = 32'h1 << parent_of(j);
      wr(3'd4, 32'h7FF & ~(32'h1 << j));
      wr(3'd1, ~pb);
      pulse_sub(11'(1 << j));
      @(negedge clk); @(negedge clk);
      chk("R4 irq via sub", {31'b0, irq_o}, 32'h1);
      rd(3'd3, d); chk("R3 subpnd", d, 32'h1 << j);
      rd(3'd0, d); chk("R4 parent srcpnd", d, pb);
      rd(3'd2, d); chk("R4 parent intpnd", d, pb);
      wr(3'd0, pb);
      rd(3'd0, d); chk("R4 parent re-set while sub pending", d, pb);
      wr(3'd3, 32'h1 << j);
      rd(3'd3, d); chk("R5 subpnd cleared", d, 32'h0);
      wr(3'd0, pb);
      wr(3'd2, pb);
      rd(3'd2, d); chk("R5 intpnd cleared after sub ack", d, 32'h0);
      chk("R5 irq off after sub ack", {31'b0, irq_o}, 32'h0);
    end
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h7FF);

    // R4 masked sub-source does not reach its parent
    pulse_sub(11'(1 << 4));
    @(negedge clk); @(negedge clk);
    rd(3'd3, d); chk("R3 masked sub still pending", d, 32'h10);
    rd(3'd0, d); chk("R4 masked sub no parent", d, 32'h0);
    wr(3'd4, 32'h7FF & ~32'h10);
    rd(3'd0, d); chk("R4 unmask sub sets parent", d, 32'h1 << 23);
    wr(3'd3, 32'h10);
    wr(3'd0, 32'h1 << 23);
    wr(3'd4, 32'h7FF);
    rd(3'd0, d); chk("R5 srcpnd clean", d, 32'h0);

    // R6 fixed priority and handover
    wr(3'd1, ~((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20)));
    pulse_src((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20));
    @(negedge clk);
    rd(3'd2, d); chk("R6 lowest first", d, 32'h1 << 3);
    wr(3'd0, 32'h1 << 3); wr(3'd2, 32'h1 << 3);
    rd(3'd2, d); chk("R6 next after ack", d, 32'h1 << 7);
    wr(3'd0, 32'h1 << 7); wr(3'd2, 32'h1 << 7);
    rd(3'd2, d); chk("R6 last after ack", d, 32'h1 << 20);
    wr(3'd0, 32'h1 << 20); wr(3'd2, 32'h1 << 20);

    // R6 held bit not preempted; R7 mask drops request
    wr(3'd1, ~((32'h1 << 10) | (32'h1 << 2)));
    pulse_src(32'h1 << 10);
    @(negedge clk);
    pulse_src(32'h1 << 2);
    @(negedge clk); @(negedge clk);
    rd(3'd2, d); chk("R6 held not preempted", d, 32'h1 << 10);
    rd(3'd0, d); chk("R2 both pending", d, 32'h404);
    chk("R7 irq held", {31'b0, irq_o}, 32'h1);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R7 irq drops when masked", {31'b0, irq_o}, 32'h0);
    rd(3'd2, d); chk("R7 intpnd kept while masked", d, 32'h1 << 10);
    wr(3'd1, ~((32'h1 << 10) | (32'h1 << 2)));
    chk("R7 irq back when unmasked", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h1 << 10); wr(3'd2, 32'h1 << 10);
    rd(3'd2, d); chk("R6 handover to lower", d, 32'h4);
    wr(3'd0, 32'h4); wr(3'd2, 32'h4);
    wr(3'd1, 32'hFFFF_FFFF);

    // R5 selective clears
    pulse_src((32'h1 << 1) | (32'h1 << 2) | (32'h1 << 9));
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk("R5 srcpnd selective", d, 32'h204);
    pulse_sub(11'h421);
    wr(3'd3, 32'h20);
    rd(3'd3, d); chk("R5 subpnd selective", d, 32'h401);
    rd(3'd2, d); chk("R6 nothing taken while masked", d, 32'h0);

    // R8 register map
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, d); chk("R8 mask readback", d, 32'h1234_5678);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0);
    rd(3'd1, d); chk("R8 unused write ignored", d, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R8 unused read zero", d, 32'h0);
    wr(3'd4, 32'h155);
    rd(3'd4, d); chk("R8 submask readback", d, 32'h155);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule